// File: doc/BRIEF.md
# Programmable duty-cycle clock divider

This block derives a slower clock from a fast input clock. The divide factor is not one modulus. It is the sum of two separate counts: one gives the number of input cycles the output stays high, and the other gives the number of input cycles it stays low. Setting the two counts differently gives duty cycles other than 50%. For example, counts of 4 and 6 divide by ten with a 40/60 duty cycle.

Two mode bits extend this. A pass-through bit sends the input clock straight to the output, which is a divide by one. An odd-factor bit retimes the high-to-low edge so that it lands on a falling input edge. This moves half an input cycle from the high phase to the low phase, so an odd factor such as 2+1 gives an even 1.5/1.5 split.

The counts and mode bits are sampled only on the rising input edge that starts a period. A change made mid-period therefore never cuts a phase short. A synchronous active-high reset holds the output low.

Top module: `duty_clk_div`

## Requirements
- R1: With the pass-through bit set to 1, the output equals the input clock level at every point of each input cycle.
- R2: With the pass-through bit set to 0, one output period lasts high count plus low count input cycles.
- R3: With both mode bits set to 0, the output rises on the rising input edge that starts a period. It stays high for high count input cycles, falls on a rising input edge, and stays low for low count input cycles.
- R4: With the odd-factor bit set to 1 and the pass-through bit set to 0, the output falls on the falling input edge in the middle of the last high cycle. The high time becomes high count minus one half input cycle, and the low time becomes low count plus one half.
- R5: Counts 2 and 1 in odd-factor mode give 1.5 cycles high and 1.5 cycles low. Counts 4 and 6 give 4 cycles high and 6 cycles low. Counts 5 and 5 give 5 and 5.
- R6: While reset is 1, the output is low. On the first rising input edge after reset is released, a new period starts and the output rises, using the settings present at that edge.
- R7: Settings that change during a period have no effect on that period. They take effect at the next period start.
- R8: Counts of 255 and 255 give a period of 510 input cycles, with 255 cycles in each phase (254.5 and 255.5 in odd-factor mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cnt | input | CNT_W | High-phase length in input cycles (at least 1 when dividing) |
| lo_cnt | input | CNT_W | Low-phase length in input cycles (at least 1 when dividing) |
| bypass | input | 1 | 1 passes the input clock through undivided |
| odd_mode | input | 1 | 1 moves the falling output edge onto a falling input edge |
| clk_out | output | 1 | Divided output clock |

## Verification
The assertions assume that both counts are at least 1 whenever pass-through is off, and that reset stays asserted across at least one falling input edge, so the half-cycle trim register starts from a known value. The bench respects both assumptions. It only drives counts between 1 and 255. It changes settings and reset 1 ns after an input edge, away from the rising edge that samples them. It holds reset for three input cycles.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    // Active operating mode, latched at each period start
    typedef enum logic [1:0] {
        DM_EVEN = 2'd0,
        DM_ODD  = 2'd1,
        DM_PASS = 2'd2
    } dcd_mode_e;

    // Pass-through wins over the odd-factor bit
    function automatic dcd_mode_e mode_of(input logic pass, input logic odd);
        if (pass)
            return DM_PASS;
        else if (odd)
            return DM_ODD;
        else
            return DM_EVEN;
    endfunction

endpackage

// File: rtl/dcd_phase_ctr.sv
module dcd_phase_ctr #(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    hi_in,
    input  logic [CNT_W-1:0]    lo_in,
    input  logic                pass_in,
    input  logic                odd_in,
    output dcd_pkg::dcd_mode_e  mode_q,
    output logic [CNT_W:0]      cnt_q,
    output logic [CNT_W-1:0]    hi_q,
    output logic [CNT_W-1:0]    lo_q,
    output logic                rise_q,
    output logic                lasthi_q
);
    import dcd_pkg::*;

    localparam int              SUM_W  = CNT_W + 1;
    localparam logic [SUM_W-1:0] ONE_S = SUM_W'(1);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    typedef struct packed {
        logic [SUM_W-1:0] cnt;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        dcd_mode_e        mode;
        logic             start;
        logic             rise;
        logic             lasthi;
    } st_t;

    st_t s_d, s_q;

    logic [SUM_W-1:0] per_len;
    logic [SUM_W-1:0] nxt_cnt;
    logic             wrap;

    always_comb begin
        s_d     = s_q;
        per_len = {1'b0, s_q.hi} + {1'b0, s_q.lo};
        nxt_cnt = s_q.cnt + ONE_S;
        wrap    = s_q.start || (s_q.mode == DM_PASS) || (nxt_cnt == per_len);

        if (wrap) begin
            // period boundary: capture the new settings
            s_d.cnt    = '0;
            s_d.hi     = hi_in;
            s_d.lo     = lo_in;
            s_d.mode   = mode_of(pass_in, odd_in);
            s_d.start  = 1'b0;
            s_d.rise   = ~pass_in;
            s_d.lasthi = ~pass_in && (hi_in == ONE_C);
        end else begin
            s_d.cnt    = nxt_cnt;
            s_d.rise   = nxt_cnt < {1'b0, s_q.hi};
            s_d.lasthi = (nxt_cnt + ONE_S) == {1'b0, s_q.hi};
        end

        if (rst) begin
            s_d        = '0;
            s_d.mode   = DM_EVEN;
            s_d.start  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign mode_q   = s_q.mode;
    assign cnt_q    = s_q.cnt;
    assign hi_q     = s_q.hi;
    assign lo_q     = s_q.lo;
    assign rise_q   = s_q.rise;
    assign lasthi_q = s_q.lasthi;

endmodule

// File: rtl/dcd_half_trim.sv
module dcd_half_trim (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic kill_q
);
    logic kill_d;

    // Sampled on the falling edge: cuts the last high cycle in half
    always_comb begin
        kill_d = arm;
        if (rst)
            kill_d = 1'b0;
    end

    always_ff @(negedge clk) begin
        kill_q <= kill_d;
    end

endmodule

// File: rtl/dcd_out_mux.sv
module dcd_out_mux (
    input  logic               clk_in,
    input  dcd_pkg::dcd_mode_e mode,
    input  logic               rise,
    input  logic               kill,
    output logic               clk_out
);
    import dcd_pkg::*;

    always_comb begin
        if (mode == DM_PASS)
            clk_out = clk_in;
        else
            clk_out = rise & ~kill;
    end

endmodule

// File: rtl/duty_clk_div.sv
module duty_clk_div #(
    parameter int CNT_W = 8
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             bypass,
    input  logic             odd_mode,
    output logic             clk_out
);
    import dcd_pkg::*;

    dcd_mode_e        mode_w;
    logic [CNT_W:0]   cnt_w;
    logic [CNT_W-1:0] hi_w;
    logic [CNT_W-1:0] lo_w;
    logic             rise_w;
    logic             lasthi_w;
    logic             kill_w;
    logic             arm_w;

    dcd_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk_in),
        .rst      (rst),
        .hi_in    (hi_cnt),
        .lo_in    (lo_cnt),
        .pass_in  (bypass),
        .odd_in   (odd_mode),
        .mode_q   (mode_w),
        .cnt_q    (cnt_w),
        .hi_q     (hi_w),
        .lo_q     (lo_w),
        .rise_q   (rise_w),
        .lasthi_q (lasthi_w)
    );

    assign arm_w = lasthi_w && (mode_w == DM_ODD);

    dcd_half_trim u_trim (
        .clk    (clk_in),
        .rst    (rst),
        .arm    (arm_w),
        .kill_q (kill_w)
    );

    dcd_out_mux u_mux (
        .clk_in  (clk_in),
        .mode    (mode_w),
        .rise    (rise_w),
        .kill    (kill_w),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/duty_clk_div_chk.sv
module duty_clk_div_chk #(
    parameter int CNT_W = 8
) (
    input logic               clk_in,
    input logic               rst,
    input dcd_pkg::dcd_mode_e mode,
    input logic [CNT_W:0]     cnt,
    input logic [CNT_W-1:0]   hi,
    input logic [CNT_W-1:0]   lo,
    input logic               rise,
    input logic               kill
);
    import dcd_pkg::*;

    assert_pass_idle_R1: assert property (@(posedge clk_in) disable iff (rst)
        (mode == DM_PASS) |-> (cnt == '0 && !rise));

    assert_cnt_in_period_R2: assert property (@(posedge clk_in) disable iff (rst)
        (mode != DM_PASS && cnt != '0) |-> (cnt < ({1'b0, hi} + {1'b0, lo})));

    assert_rise_at_start_R3: assert property (@(posedge clk_in) disable iff (rst)
        $rose(rise) |-> (cnt == '0));

    assert_trim_only_odd_R4: assert property (@(posedge clk_in) disable iff (rst)
        kill |-> (mode == DM_ODD));

    assert_cfg_held_R7: assert property (@(posedge clk_in) disable iff (rst)
        (cnt != '0) |-> $stable({hi, lo, mode}));

endmodule

bind duty_clk_div duty_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_in (clk_in),
    .rst    (rst),
    .mode   (mode_w),
    .cnt    (cnt_w),
    .hi     (hi_w),
    .lo     (lo_w),
    .rise   (rise_w),
    .kill   (kill_w)
);

// File: tb/duty_clk_div_test.sv
`timescale 1ns/1ps
module duty_clk_div_test;

    logic       clk_in = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] hi_cnt = 8'd1;
    logic [7:0] lo_cnt = 8'd1;
    logic       bypass = 1'b0;
    logic       odd_mode = 1'b0;
    logic       clk_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk_in = ~clk_in;

    duty_clk_div #(.CNT_W(8)) uut (
        .clk_in   (clk_in),
        .rst      (rst),
        .hi_cnt   (hi_cnt),
        .lo_cnt   (lo_cnt),
        .bypass   (bypass),
        .odd_mode (odd_mode),
        .clk_out  (clk_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // one sample per half input cycle, 1 ns after each edge
    task automatic sample(output logic s);
        @(posedge clk_in or negedge clk_in);
        #1;
        s = clk_out;
    endtask

    // consume samples until the output is high
    task automatic wait_rise();
        logic s;
        for (int i = 0; i < 4096; i++) begin
            sample(s);
            if (s === 1'b1) return;
        end
    endtask

    // count further samples equal to v; the first differing one is consumed
    task automatic run_len(input logic v, output int n);
        logic s;
        n = 0;
        for (int i = 0; i < 4096; i++) begin
            sample(s);
            if (s !== v) return;
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk_in); #1;
        rst = 1'b1;
        repeat (3) @(negedge clk_in);
        #1;
        rst = 1'b0;
    endtask

    // measure one period: high and low lengths in half cycles
    task automatic measure(output int hh, output int lh);
        int n;
        wait_rise();
        run_len(1'b1, n); hh = n + 1;
        run_len(1'b0, n); lh = n + 1;
    endtask

    task automatic run_cfg(input int h, input int l, input logic od, input string tag);
        int hh, lh;
        hi_cnt = 8'(h); lo_cnt = 8'(l); odd_mode = od; bypass = 1'b0;
        do_reset();
        measure(hh, lh);
        chk({tag, " high halves"}, hh, od ? 2*h - 1 : 2*h);
        chk({tag, " low halves"},  lh, od ? 2*l + 1 : 2*l);
        chk({"R2 period halves ", tag}, hh + lh, 2*(h + l));
    endtask

    initial begin
        int hh, lh, n;
        logic s;

        // R6: output low while reset is held
        hi_cnt = 8'd3; lo_cnt = 8'd2;
        repeat (2) @(posedge clk_in);
        for (int i = 0; i < 6; i++) begin
            sample(s);
            chk("R6 low in reset", int'(s), 0);
        end
        // release just after a falling edge; the next rising edge starts a period
        @(negedge clk_in); #1;
        rst = 1'b0;
        chk("R6 low before first edge", int'(clk_out), 0);
        @(posedge clk_in); #1;
        chk("R6 rises on first edge", int'(clk_out), 1);

        // R3, R4: sweep small counts in both edge modes
        for (int h = 1; h <= 6; h++)
            for (int l = 1; l <= 6; l++)
                for (int o = 0; o < 2; o++)
                    run_cfg(h, l, 1'(o), (o != 0) ? "R4" : "R3");

        // R5: named examples
        run_cfg(2, 1, 1'b1, "R5 2/1 odd");
        run_cfg(2, 1, 1'b0, "R5 2/1 even");
        run_cfg(4, 6, 1'b0, "R5 4/6");
        run_cfg(5, 5, 1'b0, "R5 5/5");

        // R8: largest counts
        run_cfg(255, 255, 1'b0, "R8 max even");
        run_cfg(255, 255, 1'b1, "R8 max odd");

        // R7: a change made mid-period waits for the next period
        hi_cnt = 8'd3; lo_cnt = 8'd3; odd_mode = 1'b0; bypass = 1'b0;
        do_reset();
        wait_rise();
        hi_cnt = 8'd1; lo_cnt = 8'd1;
        run_len(1'b1, n); hh = n + 1;
        chk("R7 current high kept", hh, 6);
        lo_cnt = 8'd4;
        run_len(1'b0, n); lh = n + 1;
        chk("R7 current low kept", lh, 6);
        run_len(1'b1, n); hh = n + 1;
        chk("R7 new high applied", hh, 2);
        run_len(1'b0, n); lh = n + 1;
        chk("R7 new low applied", lh, 8);

        // R1: pass-through follows the input clock level
        bypass = 1'b1;
        do_reset();
        @(posedge clk_in);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk_in or negedge clk_in);
            #1;
            chk("R1 follows input", int'(clk_out), int'(clk_in));
        end
        bypass = 1'b0;

        report();
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
        $finish;
    end

endmodule